// File: doc/BRIEF.md
# PWM Fault Shutdown Gate

This block sits between a PWM generator and the output pins. When the external fault input asserts, it forces every PWM channel to a safe idle state. The idle state can be driven low, driven high, or released, in which case the output-enable is withdrawn. A sticky status bit records that a shutdown happened.

Restart follows one of two selectable policies. In the software policy the status bit stays set until software pulses a clear, and that clear takes effect only once the fault has gone away. In the automatic policy the block waits for the next period-start strobe after the fault has gone. The outputs come back at that boundary, so a period never begins part-way through and no short pulse reaches the pins.

The fault input is asynchronous. A two-flop synchronizer brings it into the clock domain before any logic uses it. Once the synchronized fault is high, the outputs are gated in the same cycle, without waiting for the status register.

Top module: `pwm_fault_guard`

## Requirements
- R1: During reset and right after it, `status` is 0, `pwm_out` equals `pwm_in`, and `pwm_oe` is all ones.
- R2: With `status` 0 and no synchronized fault, `pwm_out` follows `pwm_in` in the same cycle and `pwm_oe` is all ones.
- R3: Say `fault_in` is high before rising edge k. The outputs still follow `pwm_in` after edge k. They are in the idle state after edge k+1. `status` reads 1 after edge k+2.
- R4: Idle state encoding by `safe_level`:
  - 2'b00: `pwm_out` all zeros, `pwm_oe` all ones.
  - 2'b01: `pwm_out` all ones, `pwm_oe` all ones.
  - 2'b10 or 2'b11: `pwm_out` all zeros, `pwm_oe` all zeros.
- R5: In software policy (`auto_restart`=0), `status` stays 1 after the fault ends for as long as no clear is given, and the outputs stay idle.
- R6: In software policy, a `status_clr` high at an edge where the synchronized fault is low clears `status` at that edge. The outputs follow `pwm_in` from the next cycle.
- R7: A `status_clr` given while the synchronized fault is high is ignored: `status` stays 1 and the outputs stay idle.
- R8: In automatic policy (`auto_restart`=1), after the fault ends the outputs stay idle until a cycle with `period_start` high. In that cycle the outputs follow `pwm_in`, and `status` is 0 after that edge.
- R9: In automatic policy, `status_clr` has no effect.
- R10: In automatic policy, a `period_start` that comes while the synchronized fault is still high leaves `status` at 1 and the outputs idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_in | input | CHANNELS | Raw PWM drive from the generator |
| period_start | input | 1 | One-cycle strobe in the first cycle of each PWM period |
| fault_in | input | 1 | Asynchronous shutdown request, active high |
| auto_restart | input | 1 | 1 = automatic restart at a period boundary, 0 = software restart |
| safe_level | input | 2 | Idle state while shut down (see R4) |
| status_clr | input | 1 | Software request to clear the shutdown status |
| status | output | 1 | Sticky shutdown status |
| pwm_out | output | CHANNELS | Gated PWM output |
| pwm_oe | output | CHANNELS | Output-enable per channel; 0 requests tri-state |

## Verification
The bench checks the exact cycle at which the fault takes hold. A synchronizer with one stage too few or too many would gate the outputs a cycle early or late. It also tries a software clear while the fault is still present; a design that accepts it would resume the outputs into a live fault. In automatic policy it ends the fault mid-period and checks that nothing resumes before the strobe, since a design that restarts on fault release alone would emit a runt pulse. It also checks that the output already passes during the strobe cycle itself, so a design that waits one more cycle would clip the first cycle of each period.

// File: rtl/pwm_fault_guard.sv
module pwm_fault_guard #(
  parameter int CHANNELS = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CHANNELS-1:0] pwm_in,
  input  logic                period_start,
  input  logic                fault_in,
  input  logic                auto_restart,
  input  logic [1:0]          safe_level,
  input  logic                status_clr,
  output logic                status,
  output logic [CHANNELS-1:0] pwm_out,
  output logic [CHANNELS-1:0] pwm_oe
);

  logic [1:0] sync_q;
  logic       fault_s;
  logic       restart_now;
  logic       sw_clear;
  logic       shut;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], fault_in};

  assign fault_s     = sync_q[1];
  assign restart_now = auto_restart & period_start & ~fault_s;
  assign sw_clear    = ~auto_restart & status_clr & ~fault_s;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                     status <= 1'b0;
    else if (fault_s)               status <= 1'b1;
    else if (restart_now | sw_clear) status <= 1'b0;

  assign shut    = fault_s | (status & ~restart_now);
  assign pwm_out = shut ? {CHANNELS{safe_level == 2'b01}} : pwm_in;
  assign pwm_oe  = shut ? {CHANNELS{~safe_level[1]}} : {CHANNELS{1'b1}};

  AST_FAULT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
    fault_s |=> status); // R3
  AST_SW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    status && !auto_restart && !status_clr |=> status); // R5
  AST_CLR_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    status && fault_s && status_clr |=> status); // R7
  AST_AUTO_BOUNDARY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(status) && $past(auto_restart) |-> $past(period_start)); // R8
  AST_AUTO_NOCLR: assert property (@(posedge clk) disable iff (!rst_n)
    status && auto_restart && !period_start |=> status); // R9
  AST_IDLE_OE: assert property (@(posedge clk) disable iff (!rst_n)
    status && !auto_restart |-> pwm_oe == {CHANNELS{~safe_level[1]}}); // R4

endmodule

// File: tb/sim_pwm_fault_guard.sv
module sim_pwm_fault_guard;
  localparam int CH = 2;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [CH-1:0] pwm_in = '0;
  logic          period_start = 1'b0;
  logic          fault_in = 1'b0;
  logic          auto_restart = 1'b0;
  logic [1:0]    safe_level = 2'b00;
  logic          status_clr = 1'b0;
  logic          status;
  logic [CH-1:0] pwm_out;
  logic [CH-1:0] pwm_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pwm_fault_guard #(.CHANNELS(CH)) u0 (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .period_start(period_start),
    .fault_in(fault_in), .auto_restart(auto_restart), .safe_level(safe_level),
    .status_clr(status_clr), .status(status), .pwm_out(pwm_out), .pwm_oe(pwm_oe));

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    #5;
  endtask

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic t_reset;
    pwm_in = 2'b10;
    #3;
    check("R1 status in reset", {7'd0, status}, 8'd0);
    check("R1 out in reset", {6'd0, pwm_out}, 8'h2);
    tick(2);
    rst_n = 1'b1;
    tick(1);
    check("R1 status", {7'd0, status}, 8'd0);
    check("R1 oe", {6'd0, pwm_oe}, 8'h3);
  endtask

  task automatic t_pass;
    for (int i = 0; i < 4; i++) begin
      pwm_in = i[1:0];
      #1;
      check("R2 passthrough", {6'd0, pwm_out}, 8'(i));
      check("R2 oe", {6'd0, pwm_oe}, 8'h3);
      tick(1);
    end
  endtask

  task automatic t_sw_restart;
    auto_restart = 1'b0; safe_level = 2'b00; pwm_in = 2'b11;
    fault_in = 1'b1;
    tick(1);
    check("R3 one edge still passes", {6'd0, pwm_out}, 8'h3);
    tick(1);
    check("R3 gated after two edges", {6'd0, pwm_out}, 8'h0);
    check("R3 status not yet", {7'd0, status}, 8'd0);
    tick(1);
    check("R3 status set", {7'd0, status}, 8'd1);
    fault_in = 1'b0;
    tick(4);
    check("R5 status sticky", {7'd0, status}, 8'd1);
    check("R5 output idle", {6'd0, pwm_out}, 8'h0);
    status_clr = 1'b1;
    tick(1);
    status_clr = 1'b0;
    check("R6 status cleared", {7'd0, status}, 8'd0);
    check("R6 output resumes", {6'd0, pwm_out}, 8'h3);
  endtask

  task automatic t_levels;
    auto_restart = 1'b0; pwm_in = 2'b00; safe_level = 2'b01;
    fault_in = 1'b1;
    tick(3);
    check("R4 idle high out", {6'd0, pwm_out}, 8'h3);
    check("R4 idle high oe", {6'd0, pwm_oe}, 8'h3);
    pwm_in = 2'b11;
    safe_level = 2'b10;
    #1;
    check("R4 tristate out", {6'd0, pwm_out}, 8'h0);
    check("R4 tristate oe", {6'd0, pwm_oe}, 8'h0);
    safe_level = 2'b11;
    #1;
    check("R4 tristate oe 11", {6'd0, pwm_oe}, 8'h0);
    status_clr = 1'b1;
    tick(1);
    status_clr = 1'b0;
    check("R7 clear ignored status", {7'd0, status}, 8'd1);
    check("R7 clear ignored oe", {6'd0, pwm_oe}, 8'h0);
    fault_in = 1'b0;
    tick(3);
    status_clr = 1'b1;
    tick(1);
    status_clr = 1'b0;
    safe_level = 2'b00;
    check("R6 clear after fault", {7'd0, status}, 8'd0);
  endtask

  task automatic t_auto;
    auto_restart = 1'b1; safe_level = 2'b00; pwm_in = 2'b11;
    fault_in = 1'b1;
    tick(3);
    check("R8 auto status set", {7'd0, status}, 8'd1);
    fault_in = 1'b0;
    tick(3);
    check("R8 no mid-period resume", {6'd0, pwm_out}, 8'h0);
    status_clr = 1'b1;
    tick(1);
    status_clr = 1'b0;
    check("R9 clear ignored in auto", {7'd0, status}, 8'd1);
    check("R9 output idle", {6'd0, pwm_out}, 8'h0);
    period_start = 1'b1;
    #1;
    check("R8 passes in strobe cycle", {6'd0, pwm_out}, 8'h3);
    tick(1);
    period_start = 1'b0;
    check("R8 status cleared at strobe", {7'd0, status}, 8'd0);
    check("R8 output after strobe", {6'd0, pwm_out}, 8'h3);
  endtask

  task automatic t_auto_persist;
    auto_restart = 1'b1; pwm_in = 2'b01;
    fault_in = 1'b1;
    tick(3);
    period_start = 1'b1;
    #1;
    check("R10 strobe during fault out", {6'd0, pwm_out}, 8'h0);
    tick(1);
    period_start = 1'b0;
    check("R10 status kept", {7'd0, status}, 8'd1);
    fault_in = 1'b0;
    tick(3);
    period_start = 1'b1;
    tick(1);
    period_start = 1'b0;
    check("R8 later strobe restarts", {7'd0, status}, 8'd0);
    check("R8 later strobe output", {6'd0, pwm_out}, 8'h1);
  endtask

  initial begin
    #(200000 * 20);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_pass();
    t_sw_restart();
    t_levels();
    t_auto();
    t_auto_persist();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule